// File: doc/BRIEF.md
# Interleaved Dual-Channel PWM Timing Generator

This block is the digital timebase and modulator for two PWM channels running in antiphase. A counter-based oscillator alternates between a high interval and a low interval, each programmed by its own count. A steering bit flips at every oscillator period boundary. Successive oscillator periods therefore go to channel 1 and channel 2 in turn. Each channel switches at half the oscillator rate, and the two channels are offset by one oscillator period, which is 180 degrees.

Each channel has a set/reset latch. The latch sets at the start of its own oscillator period. It clears, cycle by cycle, when that channel's digital peak-current compare flag is high. It is also held off during the oscillator low interval just before its own next start. This hold-off guarantees a minimum off time. The maximum duty cycle per channel is therefore (2H+L)/(2(H+L)), which equals one minus half the oscillator off fraction.

When the run input is low, both latches are cleared and the steering returns to channel 1. A new count takes effect only at the next oscillator period boundary.

Top module: `ilv_pwm2_gen`

## Requirements
- R1: The oscillator high interval lasts `hi_cnt` clocks and its low interval lasts `lo_cnt` clocks, so one oscillator period is H+L clocks. A count of 0 acts as 1.
- R2: `stb` pulses for one clock at the first cycle of each oscillator period. Bit 0 (channel 1) and bit 1 (channel 2) pulse on alternate periods. After run rises, the first pulse is on bit 0, on the clock after run is first sampled high. The strobes of the two channels are spaced exactly H+L clocks apart.
- R3: If `trip[k]` is low in the strobe cycle of channel k, then `drv[k]` goes high on the next clock. Bit 0 is channel 1 and bit 1 is channel 2.
- R4: A high `trip[k]` sampled at a clock edge drives `drv[k]` low after that edge. `drv[k]` then stays low until the next strobe of channel k.
- R5: With no trips, `drv[k]` is high for exactly 2H+L clocks in each window of 2(H+L) clocks that starts at its strobe. It is forced low during the other channel's low interval. An oscillator high fraction of 20% (H=1, L=4) gives a 60% clamp. A fraction of 80% (H=4, L=1) gives a 90% clamp.
- R6: If `trip[k]` is already high in the strobe cycle of channel k, then `drv[k]` stays low for that entire channel period and does not pulse.
- R7: When `run` is low at a clock edge, both `drv` and `stb` are zero after that edge. The next run starts with channel 1.
- R8: A change on `hi_cnt` or `lo_cnt` partway through a period leaves the current period unchanged. The new counts apply from the next period boundary.
- R9: While `rst_n` is low (synchronous reset), `drv` and `stb` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enable; low clears both channels and rewinds the steering |
| hi_cnt | input | CNT_W | Oscillator high-interval length in clocks (0 acts as 1) |
| lo_cnt | input | CNT_W | Oscillator low-interval length in clocks (0 acts as 1) |
| trip | input | 2 | Per-channel peak-current compare flag; bit 0 is channel 1 |
| drv | output | 2 | PWM outputs; bit 0 is channel 1 |
| stb | output | 2 | Per-channel cycle-start strobes; bit 0 is channel 1 |

## Verification
Each kind of internal fault shows up at the ports within one channel period.

- A wrong steering bit makes two consecutive strobes land on the same `stb` bit, or puts the blanking window on the wrong channel. Either error appears within one oscillator period.
- An off-by-one in the interval counter or in its snapshot moves the next strobe by one clock. It also changes the count of high clocks in a channel window by one. Both show up at the next channel period.
- A latch stuck high or with a lost reset leaves `drv` high one clock past a trip or into the blanking window. This is caught on the very next cycle.

// File: rtl/pwm2_pkg.sv
// Shared definitions for the interleaved dual PWM generator.
// Assumes exactly two channels; bit 0 is channel 1 everywhere.
package pwm2_pkg;
    localparam int unsigned PWM_NCH = 2;

    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } osc_phase_e;
endpackage

// File: rtl/pwm2_timebase.sv
// Oscillator timebase: counts a high interval then a low interval.
// Counts are snapshotted at each period boundary (and while idle), so a
// change mid-period only affects the next period. A count of 0 acts as 1.
// Assumes run is synchronous; leaving run low rewinds to the period start.
module pwm2_timebase
    import pwm2_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    output logic             act,
    output logic             ph_hi,
    output logic             prd_start,
    output logic             prd_wrap
);
    logic [CNT_W-1:0] hi_snap;
    logic [CNT_W-1:0] lo_snap;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hi_last;
    logic [CNT_W-1:0] lo_last;
    osc_phase_e       ph;
    logic             hi_end;
    logic             lo_end;

    // last index of each interval, with zero treated as one clock
    assign hi_last = (hi_snap == '0) ? '0 : hi_snap - 1'b1;
    assign lo_last = (lo_snap == '0) ? '0 : lo_snap - 1'b1;

    // interval end detection
    assign hi_end = (ph == PH_HI) && (cnt == hi_last);
    assign lo_end = (ph == PH_LO) && (cnt == lo_last);

    assign ph_hi     = act && (ph == PH_HI);
    assign prd_start = act && (ph == PH_HI) && (cnt == '0);
    assign prd_wrap  = act && lo_end;

    // phase and position counter of the oscillator
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            act <= 1'b0;
            ph  <= PH_HI;
            cnt <= '0;
        end else if (!act) begin
            act <= 1'b1;
        end else if (hi_end) begin
            ph  <= PH_LO;
            cnt <= '0;
        end else if (lo_end) begin
            ph  <= PH_HI;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // count snapshot, reloaded only at a period boundary or while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_snap <= '0;
            lo_snap <= '0;
        end else if (!act || prd_wrap) begin
            hi_snap <= hi_cnt;
            lo_snap <= lo_cnt;
        end
    end
endmodule

// File: rtl/pwm2_steer.sv
// Steering stage: a toggle bit that hands alternate oscillator periods to
// channel 1 and channel 2. Produces each channel's start pulse and its
// blanking window (the other channel's low interval, which precedes this
// channel's next start). Assumes the timebase signals are already qualified by act.
module pwm2_steer
    import pwm2_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               act,
    input  logic               ph_hi,
    input  logic               prd_start,
    input  logic               prd_wrap,
    output logic [PWM_NCH-1:0] start,
    output logic [PWM_NCH-1:0] blank
);
    logic sel;

    // toggle at each period wrap; rewinds to channel 1 when halted
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sel <= 1'b0;
        end else if (prd_wrap) begin
            sel <= ~sel;
        end
    end

    for (genvar k = 0; k < PWM_NCH; k++) begin : g_ch
        assign start[k] = prd_start && (sel == 1'(k));
        assign blank[k] = act && !ph_hi && (sel != 1'(k));
    end
endmodule

// File: rtl/pwm2_latch.sv
// Per-channel set/reset latch. Reset (trip or blanking) dominates set, so a
// trip present at the start cycle yields no pulse. Registered output, so
// the pulse appears one clock after the start strobe and cannot glitch.
module pwm2_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic start,
    input  logic blank,
    input  logic trip,
    output logic q
);
    // reset-dominant latch update
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            q <= 1'b0;
        end else if (trip || blank) begin
            q <= 1'b0;
        end else if (start) begin
            q <= 1'b1;
        end
    end
endmodule

// File: rtl/ilv_pwm2_gen.sv
// Interleaved dual-channel PWM timing generator (top).
// Timebase -> steering -> one latch per channel. Channel max duty is
// (2H+L)/(2(H+L)). Bit 0 of every vector is channel 1.
module ilv_pwm2_gen
    import pwm2_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [CNT_W-1:0]   hi_cnt,
    input  logic [CNT_W-1:0]   lo_cnt,
    input  logic [PWM_NCH-1:0] trip,
    output logic [PWM_NCH-1:0] drv,
    output logic [PWM_NCH-1:0] stb
);
    logic               act;
    logic               ph_hi;
    logic               prd_start;
    logic               prd_wrap;
    logic [PWM_NCH-1:0] start;
    logic [PWM_NCH-1:0] blank;

    pwm2_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .hi_cnt    (hi_cnt),
        .lo_cnt    (lo_cnt),
        .act       (act),
        .ph_hi     (ph_hi),
        .prd_start (prd_start),
        .prd_wrap  (prd_wrap)
    );

    pwm2_steer u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .act       (act),
        .ph_hi     (ph_hi),
        .prd_start (prd_start),
        .prd_wrap  (prd_wrap),
        .start     (start),
        .blank     (blank)
    );

    for (genvar k = 0; k < PWM_NCH; k++) begin : g_lat
        pwm2_latch u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .start (start[k]),
            .blank (blank[k]),
            .trip  (trip[k]),
            .q     (drv[k])
        );
    end

    assign stb = start;
endmodule

// File: rtl/pwm2_gen_chk.sv
// Port-level property checker for ilv_pwm2_gen, attached with bind.
module pwm2_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic [1:0] trip,
    input logic [1:0] drv,
    input logic [1:0] stb
);
    // R2
    stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));

    // R3
    set_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb[0] && !trip[0] && run) |=> drv[0]);

    // R3
    set_ch2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb[1] && !trip[1] && run) |=> drv[1]);

    // R4
    trip_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip[0] |=> !drv[0]);

    // R4
    trip_ch2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip[1] |=> !drv[1]);

    // R7
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (drv == 2'b00 && stb == 2'b00));

    // R6
    rise_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv[0]) |-> $past(stb[0]));

    // R6
    rise_ch2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv[1]) |-> $past(stb[1]));
endmodule

bind ilv_pwm2_gen pwm2_gen_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .trip  (trip),
    .drv   (drv),
    .stb   (stb)
);

// File: tb/ilv_pwm2_gen_test.sv
`timescale 1ns/1ps
module ilv_pwm2_gen_test;
    localparam int unsigned CNT_W = 8;

    logic             clk    = 1'b0;
    logic             rst_n  = 1'b0;
    logic             run    = 1'b0;
    logic [CNT_W-1:0] hi_cnt = 8'd1;
    logic [CNT_W-1:0] lo_cnt = 8'd1;
    logic [1:0]       trip   = 2'b00;
    logic [1:0]       drv;
    logic [1:0]       stb;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_n = 0;
    bit done  = 1'b0;

    // expectation model state
    bit       m_act = 1'b0;
    int       m_j, m_ps, m_ph, m_pl, m_pi;
    bit [1:0] m_lat = 2'b00;

    // clamp window bookkeeping
    bit    clamp_on = 1'b0;
    string clamp_tag = "R5";
    int    exp_hi, exp_gap;
    int    hic[2];
    bit    seen[2];
    int    last_t[2];

    always #2 clk = ~clk;

    ilv_pwm2_gen #(.CNT_W(CNT_W)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .hi_cnt (hi_cnt),
        .lo_cnt (lo_cnt),
        .trip   (trip),
        .drv    (drv),
        .stb    (stb)
    );

    function automatic int eff(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    function automatic bit [1:0] exp_stb();
        bit [1:0] s = 2'b00;
        if (m_act && m_j == m_ps) s[m_pi % 2] = 1'b1;
        return s;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act_v, input logic [31:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
                     req, what, act_v, exp_v, cyc_n);
        end
    endtask

    // advance the model by one clock edge using the inputs sampled there
    task automatic model_step(input bit en, input int h, input int l, input bit [1:0] t);
        int pos;
        int c;
        if (!en) begin
            m_act = 1'b0;
            m_lat = 2'b00;
        end else if (!m_act) begin
            m_act = 1'b1;
            m_j = 0; m_ps = 0; m_pi = 0;
            m_ph = eff(h); m_pl = eff(l);
        end else begin
            pos = m_j - m_ps;
            c   = m_pi % 2;
            for (int k = 0; k < 2; k++) begin
                if (t[k])                      m_lat[k] = 1'b0;
                else if (c != k && pos >= m_ph) m_lat[k] = 1'b0;
                else if (c == k && pos == 0)   m_lat[k] = 1'b1;
            end
            m_j++;
            if (pos == m_ph + m_pl - 1) begin
                m_ps = m_j;
                m_pi++;
                m_ph = eff(h);
                m_pl = eff(l);
            end
        end
    endtask

    task automatic cyc(input bit r, input int h, input int l,
                       input bit [1:0] t, input string req);
        @(negedge clk);
        run    = r;
        hi_cnt = h[CNT_W-1:0];
        lo_cnt = l[CNT_W-1:0];
        trip   = t;
        model_step(rst_n && r, h, l, t);
        @(posedge clk);
        #1;
        cyc_n++;
        check(req, "drv", 32'(drv), 32'(m_lat));
        check("R2", "stb", 32'(stb), 32'(exp_stb()));
        if (clamp_on) begin
            for (int k = 0; k < 2; k++) begin
                if (stb[k]) begin
                    if (seen[k]) check(clamp_tag, "high clocks per channel window", hic[k], exp_hi);
                    hic[k]    = 0;
                    seen[k]   = 1'b1;
                    last_t[k] = cyc_n;
                    if (k == 1 && seen[0]) check("R2", "strobe offset", cyc_n - last_t[0], exp_gap);
                end else if (drv[k]) begin
                    hic[k]++;
                end
            end
        end
    endtask

    task automatic clamp_run(input int h, input int l, input int n, input string tag);
        clamp_on  = 1'b1;
        clamp_tag = tag;
        exp_hi    = 2 * eff(h) + eff(l);
        exp_gap   = eff(h) + eff(l);
        seen[0] = 1'b0; seen[1] = 1'b0;
        hic[0]  = 0;    hic[1]  = 0;
        for (int i = 0; i < n; i++) cyc(1'b1, h, l, 2'b00, tag);
        clamp_on = 1'b0;
        for (int i = 0; i < 3; i++) cyc(1'b0, h, l, 2'b00, "R7");
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int h, l;
        bit r;
        bit [1:0] t;
        void'($urandom(32'd5150));
        // R9: reset dominates run
        for (int i = 0; i < 4; i++) cyc(1'b1, 3, 2, 2'b00, "R9");
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) cyc(1'b0, 3, 2, 2'b00, "R7");

        // R5: clamp at several oscillator duties
        clamp_run(1, 4, 60, "R5");
        clamp_run(4, 1, 60, "R5");
        clamp_run(3, 3, 60, "R5");
        // R1: zero counts act as one
        clamp_run(0, 0, 20, "R1");
        clamp_run(2, 0, 30, "R1");

        // R6: trip present at channel 1 start
        cyc(1'b1, 3, 3, 2'b00, "R7");
        cyc(1'b1, 3, 3, 2'b01, "R6");
        for (int i = 0; i < 20; i++) cyc(1'b1, 3, 3, 2'b00, "R6");
        // R4: trip pulses partway through a pulse
        for (int i = 0; i < 30; i++) cyc(1'b1, 5, 3, (i % 7 == 3) ? 2'b10 : ((i % 11 == 4) ? 2'b01 : 2'b00), "R4");
        // R3: plain set with no trip
        for (int i = 0; i < 16; i++) cyc(1'b1, 5, 3, 2'b00, "R3");
        // R7: halt mid-period and restart on channel 1
        for (int i = 0; i < 4; i++) cyc(1'b0, 5, 3, 2'b00, "R7");
        for (int i = 0; i < 6; i++) cyc(1'b1, 3, 2, 2'b00, "R7");
        // R8: program change mid-period
        for (int i = 0; i < 2; i++) cyc(1'b1, 3, 2, 2'b00, "R8");
        for (int i = 0; i < 40; i++) cyc(1'b1, 6, 5, 2'b00, "R8");

        // random mix
        r = 1'b1; h = 4; l = 2;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 199) == 0) r = ~r;
            if ($urandom_range(0, 99) == 0) begin
                h = $urandom_range(0, 7);
                l = $urandom_range(0, 7);
            end
            t[0] = ($urandom_range(0, 15) == 0);
            t[1] = ($urandom_range(0, 15) == 0);
            cyc(r, h, l, t, "R4");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule